// File: doc/BRIEF.md
# Configuration Change Unlock Guard

This block guards protected operations behind a keyed unlock. Software writes an 8-bit key into one register of a small register block. If the key is one of two signatures, the guard opens a short window. During that window one class of protected action is allowed: either changes to protected I/O registers or self-programming and program-memory load instructions. The window runs out on its own, and interrupt acceptance is held off while it is open.

The window is measured in retired instructions, not in clock cycles. A strobe from the CPU pipeline marks each retired instruction. A consume input reports that the protected action was carried out, and the window closes at once, so each unlock admits one change. The readback value reports which mode is live. The protected registers, the flash controller and the interrupt controller sit outside this block. They use the two enables and the interrupt-block flag.

Top module: `cfg_unlock_guard`

## Requirements
- R1: A write of 0x9D to offset 0x04 sets `prog_unlock` and `irq_block` from the next clock cycle.
- R2: A write of 0xD8 to offset 0x04 sets `io_unlock` and `irq_block` from the next clock cycle.
- R3: An open window closes on the fourth `retire` pulse after the key write. Clock cycles without `retire` do not shorten the window.
- R4: `irq_block` is high exactly while either enable is high.
- R5: `rd_data` bit 0 equals `io_unlock`, bit 1 equals `prog_unlock`, and bits 7 to 2 are always zero.
- R6: A write of any other value to offset 0x04 clears both enables and aborts an open window.
- R7: A `consume` pulse while a window is open closes it in the next cycle.
- R8: Writing either valid key restarts the count at four and selects only that key's mode, clearing the other enable. In the same cycle, a key write takes precedence over `consume` and `retire`.
- R9: After reset both enables and `irq_block` are low and `rd_data` is 0x00.
- R10: Writes to any offset other than 0x04 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset within the block |
| bus_wdata | input | 8 | Write data (key) |
| retire | input | 1 | One pulse per retired instruction |
| consume | input | 1 | Protected action carried out |
| io_unlock | output | 1 | Protected I/O register change allowed |
| prog_unlock | output | 1 | Self-programming / program-memory load allowed |
| irq_block | output | 1 | Interrupt acceptance suppressed |
| rd_data | output | 8 | Readback of the key register status |

## Verification
Each result sits one register stage behind its cause. A key write, a `consume` pulse or the closing `retire` pulse sampled at one rising edge changes the outputs right after that edge. The bench drives inputs on the falling edge. A behavioural model is updated at the next rising edge from the same inputs, and the model and all outputs are compared at the following falling edge, so every result is checked in the cycle it falls due. Directed phases cover key writes, gaps between retire pulses, bad keys, consume, mode switches, same-cycle collisions and writes to other offsets.

// File: rtl/cfg_unlock_guard.sv
module cfg_unlock_guard #(
  parameter int          ADDR_W   = 4,
  parameter int          DATA_W   = 8,
  parameter int          WINDOW   = 4,
  parameter logic [3:0]  KEY_OFFS = 4'h4,
  parameter logic [7:0]  KEY_IO   = 8'hD8,
  parameter logic [7:0]  KEY_PROG = 8'h9D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              retire,
  input  logic              consume,
  output logic              io_unlock,
  output logic              prog_unlock,
  output logic              irq_block,
  output logic [DATA_W-1:0] rd_data
);
  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WINDOW);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  typedef enum logic [1:0] {M_OFF, M_IO, M_PROG} mode_t;

  mode_t            mode_q;
  logic [CNT_W-1:0] cnt_q;

  wire key_hit  = bus_wr && (bus_addr == ADDR_W'(KEY_OFFS));
  wire is_io    = bus_wdata == DATA_W'(KEY_IO);
  wire is_prog  = bus_wdata == DATA_W'(KEY_PROG);
  wire open_now = mode_q != M_OFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_OFF;
      cnt_q  <= '0;
    end else if (key_hit) begin
      if (is_io) begin
        mode_q <= M_IO;
        cnt_q  <= CNT_FULL;
      end else if (is_prog) begin
        mode_q <= M_PROG;
        cnt_q  <= CNT_FULL;
      end else begin
        mode_q <= M_OFF;
        cnt_q  <= '0;
      end
    end else if (open_now && consume) begin
      mode_q <= M_OFF;
      cnt_q  <= '0;
    end else if (open_now && retire) begin
      cnt_q <= cnt_q - CNT_ONE;
      if (cnt_q <= CNT_ONE) mode_q <= M_OFF;
    end
  end

  assign io_unlock   = mode_q == M_IO;
  assign prog_unlock = mode_q == M_PROG;
  assign irq_block   = open_now;
  assign rd_data     = {{(DATA_W-2){1'b0}}, prog_unlock, io_unlock};

  p_prog_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit && is_prog |=> prog_unlock && !io_unlock && irq_block);

  p_io_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit && is_io |=> io_unlock && !prog_unlock && irq_block);

  p_expire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    open_now && retire && !consume && !key_hit && cnt_q == CNT_ONE |=> !irq_block);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !retire && !consume && !key_hit |=> $stable(rd_data) && $stable(irq_block));

  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({io_unlock, prog_unlock}) <= 1);

  p_bad_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit && !is_io && !is_prog |=> !irq_block && rd_data == '0);

  p_consume_r7: assert property (@(posedge clk) disable iff (!rst_n)
    consume && !key_hit |=> !irq_block);

  p_fresh_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit && (is_io || is_prog) |=> cnt_q == CNT_FULL);
endmodule

// File: tb/cfg_unlock_guard_tb.sv
module cfg_unlock_guard_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       retire = 1'b0;
  logic       consume = 1'b0;
  logic       io_unlock, prog_unlock, irq_block;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R9";

  int m_mode = 0;
  int m_cnt = 0;

  always #10 clk = ~clk;

  cfg_unlock_guard u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .retire(retire), .consume(consume),
    .io_unlock(io_unlock), .prog_unlock(prog_unlock),
    .irq_block(irq_block), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0;
    end else if (bus_wr && bus_addr == 4'h4) begin
      if (bus_wdata == 8'hD8) begin m_mode = 1; m_cnt = 4; end
      else if (bus_wdata == 8'h9D) begin m_mode = 2; m_cnt = 4; end
      else begin m_mode = 0; m_cnt = 0; end
    end else if (m_mode != 0 && consume) begin
      m_mode = 0; m_cnt = 0;
    end else if (m_mode != 0 && retire) begin
      m_cnt = m_cnt - 1;
      if (m_cnt == 0) m_mode = 0;
    end
  end

  always @(negedge clk) begin
    logic [7:0] exp_rd;
    exp_rd = {6'b0, m_mode == 2, m_mode == 1};
    checks = checks + 1;
    if (io_unlock !== (m_mode == 1) || prog_unlock !== (m_mode == 2) ||
        irq_block !== (m_mode != 0) || rd_data !== exp_rd) begin
      errors = errors + 1;
      $display("FAIL %s: io=%b prog=%b irq=%b rd=%h expected io=%b prog=%b irq=%b rd=%h",
               cur_req, io_unlock, prog_unlock, irq_block, rd_data,
               m_mode == 1, m_mode == 2, m_mode != 0, exp_rd);
    end
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input logic wr, input logic [3:0] a, input logic [7:0] d,
                      input logic ret, input logic con);
    bus_wr = wr; bus_addr = a; bus_wdata = d; retire = ret; consume = con;
    @(negedge clk);
    bus_wr = 1'b0; retire = 1'b0; consume = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 4'h0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic expect_state(input string req, input logic io, input logic pg);
    checks = checks + 1;
    if (io_unlock !== io || prog_unlock !== pg || irq_block !== (io | pg) ||
        rd_data !== {6'b0, pg, io}) begin
      errors = errors + 1;
      $display("FAIL %s: io=%b prog=%b rd=%h expected io=%b prog=%b", req,
               io_unlock, prog_unlock, rd_data, io, pg);
    end
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    cur_req = "R9"; expect_state("R9", 1'b0, 1'b0);
    rst_n = 1'b1;
    idle(2);

    cur_req = "R1";
    step(1'b1, 4'h4, 8'h9D, 1'b0, 1'b0);
    expect_state("R1", 1'b0, 1'b1);

    cur_req = "R3";
    step(1'b0, 4'h0, 8'h00, 1'b1, 1'b0); idle(5);
    step(1'b0, 4'h0, 8'h00, 1'b1, 1'b0); idle(3);
    step(1'b0, 4'h0, 8'h00, 1'b1, 1'b0);
    expect_state("R3", 1'b0, 1'b1);
    step(1'b0, 4'h0, 8'h00, 1'b1, 1'b0);
    expect_state("R3", 1'b0, 1'b0);

    cur_req = "R2";
    step(1'b1, 4'h4, 8'hD8, 1'b0, 1'b0);
    expect_state("R2", 1'b1, 1'b0);
    cur_req = "R5"; idle(1); expect_state("R5", 1'b1, 1'b0);

    cur_req = "R7";
    step(1'b0, 4'h0, 8'h00, 1'b1, 1'b1);
    expect_state("R7", 1'b0, 1'b0);

    cur_req = "R6";
    step(1'b1, 4'h4, 8'h9D, 1'b0, 1'b0);
    step(1'b1, 4'h4, 8'h5A, 1'b0, 1'b0);
    expect_state("R6", 1'b0, 1'b0);
    step(1'b1, 4'h4, 8'hD9, 1'b0, 1'b0);
    expect_state("R6", 1'b0, 1'b0);

    cur_req = "R8";
    step(1'b1, 4'h4, 8'hD8, 1'b0, 1'b0);
    step(1'b0, 4'h0, 8'h00, 1'b1, 1'b0);
    step(1'b0, 4'h0, 8'h00, 1'b1, 1'b0);
    step(1'b1, 4'h4, 8'h9D, 1'b1, 1'b1);
    expect_state("R8", 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, 4'h0, 8'h00, 1'b1, 1'b0);
    expect_state("R8", 1'b0, 1'b1);
    step(1'b1, 4'h4, 8'h9D, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b0, 4'h0, 8'h00, 1'b1, 1'b0);
    expect_state("R8", 1'b0, 1'b1);
    step(1'b0, 4'h0, 8'h00, 1'b1, 1'b0);
    expect_state("R8", 1'b0, 1'b0);

    cur_req = "R10";
    step(1'b1, 4'h5, 8'hD8, 1'b0, 1'b0);
    step(1'b1, 4'h0, 8'h9D, 1'b0, 1'b0);
    expect_state("R10", 1'b0, 1'b0);
    step(1'b1, 4'h4, 8'hD8, 1'b0, 1'b0);
    step(1'b1, 4'hC, 8'h00, 1'b0, 1'b0);
    expect_state("R10", 1'b1, 1'b0);

    cur_req = "R4";
    for (int i = 0; i < 40; i++)
      step(((i % 7) == 0), ((i % 3) == 0) ? 4'h4 : 4'h2,
           ((i % 2) == 0) ? 8'h9D : 8'hD8, ((i % 2) == 1), ((i % 11) == 5));

    cur_req = "R9";
    rst_n = 1'b0; idle(1);
    expect_state("R9", 1'b0, 1'b0);
    rst_n = 1'b1; idle(1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule